// File: doc/BRIEF.md
# Packed-Operand Relative Address Unit

This unit serves a processor whose 32-bit instruction word holds the opcode and the operand together. The opcode sits in bits 31:24 and a 24-bit displacement fills bits 23:0. The unit sign-extends that displacement to a full 32-bit word and adds it to the address of the following instruction. From that sum it produces a branch target, a branch-to-subroutine target together with its return address, or an effective address. An effective address is either returned as data or handed to the stack as a push request.

The fetch stage presents the instruction word, the current program counter and the branch condition, and it pulses a valid strobe. One clock later the unit presents the next program counter, the effective address, an optional push request with its data, and a result-valid flag. Outputs are held between strobes. Opcodes outside the handled classes simply step to the next instruction.

Top module: `pcrel_addr_unit`

## Requirements
- R1: The displacement is bits 23:0 of the instruction word, sign-extended from bit 23 to 32 bits, so it spans -8388608 to +8388607 words.
- R2: Opcode 8'h10 (unconditional branch) gives nextPc = pcIn + 1 + displacement, with no push and effAddr = 0.
- R3: Opcode 8'h11 (conditional branch) gives the R2 target when condTrue is 1 and pcIn + 1 when condTrue is 0, with no push and effAddr = 0.
- R4: Opcode 8'h20 (branch to subroutine) ignores condTrue and always takes the R2 target. It raises pushReq with pushData = pcIn + 1, and sets effAddr = 0.
- R5: Opcode 8'h30 (load effective address) gives effAddr = pcIn + 1 + displacement, nextPc = pcIn + 1, and no push.
- R6: Opcode 8'h31 (push effective address) gives the R5 effAddr, raises pushReq with pushData equal to that address, and sets nextPc = pcIn + 1.
- R7: All address sums wrap modulo 2^32.
- R8: Any other opcode gives nextPc = pcIn + 1, effAddr = 0, pushReq = 0 and pushData = 0.
- R9: resultValid is high exactly in the cycle after a cycle with inValid high. pushReq is never high without resultValid.
- R10: While rstN is low, every output reads zero.
- R11: A cycle with inValid low leaves nextPc, effAddr and pushData unchanged, and drops resultValid and pushReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction presented this cycle |
| instrWord | input | 32 | Opcode (31:24) and displacement (23:0) |
| pcIn | input | 32 | Address of the presented instruction |
| condTrue | input | 1 | Branch condition for opcode 8'h11 |
| resultValid | output | 1 | Outputs updated from last cycle's strobe |
| nextPc | output | 32 | Next program counter |
| effAddr | output | 32 | Computed effective address |
| pushReq | output | 1 | Request to push pushData |
| pushData | output | 32 | Return address or effective address to push |

## Verification
Every result is captured by a single register, so all outputs answer one clock edge after the strobe. The bench drives at a falling edge and compares at the next falling edge, which is after the capturing rising edge and before any new stimulus. It then holds the strobe low for one cycle with the inputs changed and checks at the following falling edge that the held values stay put and that the flags have dropped. Sweeps cover each opcode class over corner displacements, program counters near both ends of the address space, and both condition values.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OPC_W  = 8;

  localparam logic [7:0] OP_BRA  = 8'h10;
  localparam logic [7:0] OP_BCND = 8'h11;
  localparam logic [7:0] OP_BSUB = 8'h20;
  localparam logic [7:0] OP_LDEA = 8'h30;
  localparam logic [7:0] OP_PSEA = 8'h31;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch a new result
    logic takeBranch;  // next pc takes the relative target
    logic pushRet;     // push the sequential address
    logic formEa;      // expose the relative target as effAddr
    logic pushEa;      // push the effective address
  } strobe_t;
endpackage

// File: rtl/pcrel_ctrl.sv
module pcrel_ctrl
  import pcrel_pkg::*;
#(
  parameter int unsigned OPCW = OPC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OPCW-1:0] opcode,
  input  logic            condTrue,
  output strobe_t         strb
);

  always_comb begin
    strb = '0;
    strb.capture = inValid;
    if (inValid) begin
      unique case (opcode)
        OPCW'(OP_BRA):  strb.takeBranch = 1'b1;
        OPCW'(OP_BCND): strb.takeBranch = condTrue;
        OPCW'(OP_BSUB): begin
          strb.takeBranch = 1'b1;
          strb.pushRet    = 1'b1;
        end
        OPCW'(OP_LDEA): strb.formEa = 1'b1;
        OPCW'(OP_PSEA): begin
          strb.formEa = 1'b1;
          strb.pushEa = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R4 / R6: at most one push source per instruction
  p_one_push_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pushRet, strb.pushEa}));

  // R4: subroutine call always transfers control
  p_call_taken_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushRet |-> strb.takeBranch);

  // R9: no strobe activity without an instruction
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> !(strb.takeBranch || strb.pushRet || strb.formEa || strb.pushEa));

endmodule

// File: rtl/pcrel_datapath.sv
module pcrel_datapath
  import pcrel_pkg::*;
#(
  parameter int unsigned WORDW = WORD_W,
  parameter int unsigned OPCW  = OPC_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [WORDW-OPCW-1:0] operand,
  input  logic [WORDW-1:0]      pcIn,
  output logic                  resultValid,
  output logic [WORDW-1:0]      nextPc,
  output logic [WORDW-1:0]      effAddr,
  output logic                  pushReq,
  output logic [WORDW-1:0]      pushData
);
  localparam int unsigned OPRW = WORDW - OPCW;

  logic [WORDW-1:0] dispExt;
  logic [WORDW-1:0] seqPc;
  logic [WORDW-1:0] relTarget;

  // R1: replicate the operand's top bit over the opcode's width
  assign dispExt   = {{OPCW{operand[OPRW-1]}}, operand};
  assign seqPc     = pcIn + WORDW'(1);
  assign relTarget = seqPc + dispExt;   // R7: natural wrap of a WORDW-bit sum

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      pushReq     <= 1'b0;
      nextPc      <= '0;
      effAddr     <= '0;
      pushData    <= '0;
    end else begin
      resultValid <= strb.capture;
      pushReq     <= strb.capture & (strb.pushRet | strb.pushEa);
      if (strb.capture) begin
        nextPc  <= strb.takeBranch ? relTarget : seqPc;
        effAddr <= strb.formEa ? relTarget : '0;
        if (strb.pushRet)     pushData <= seqPc;
        else if (strb.pushEa) pushData <= relTarget;
        else                  pushData <= '0;
      end
    end
  end

  // R9: results appear one cycle after the strobe
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> resultValid);

  // R9: a push is only offered alongside a valid result
  p_push_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    pushReq |-> resultValid);

  // R11: idle cycles keep the held values and drop the flags
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(nextPc) && $stable(effAddr) && $stable(pushData)
                       && !resultValid && !pushReq));

  // R4: return address is the sequential successor of the call
  p_ret_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushRet |=> (pushReq && pushData == $past(pcIn) + WORDW'(1)));

  // R8 / R5: without a taken branch the pc steps by one
  p_fallthrough_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.takeBranch) |=> nextPc == $past(pcIn) + WORDW'(1));

  // R6: a pushed effective address equals the exposed one
  p_pea_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushEa |=> (pushData == effAddr));

endmodule

// File: rtl/pcrel_addr_unit.sv
module pcrel_addr_unit
  import pcrel_pkg::*;
#(
  parameter int unsigned WORDW = WORD_W,
  parameter int unsigned OPCW  = OPC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WORDW-1:0] instrWord,
  input  logic [WORDW-1:0] pcIn,
  input  logic             condTrue,
  output logic             resultValid,
  output logic [WORDW-1:0] nextPc,
  output logic [WORDW-1:0] effAddr,
  output logic             pushReq,
  output logic [WORDW-1:0] pushData
);
  localparam int unsigned OPRW = WORDW - OPCW;

  strobe_t ctrlStrb;

  pcrel_ctrl #(.OPCW(OPCW)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (instrWord[WORDW-1 -: OPCW]),
    .condTrue (condTrue),
    .strb     (ctrlStrb)
  );

  pcrel_datapath #(.WORDW(WORDW), .OPCW(OPCW)) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (ctrlStrb),
    .operand     (instrWord[OPRW-1:0]),
    .pcIn        (pcIn),
    .resultValid (resultValid),
    .nextPc      (nextPc),
    .effAddr     (effAddr),
    .pushReq     (pushReq),
    .pushData    (pushData)
  );

endmodule

// File: tb/test_pcrel_addr_unit.sv
`timescale 1ns/1ps
module test_pcrel_addr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] pcIn = '0;
  logic        condTrue = 1'b0;
  logic        resultValid;
  logic [31:0] nextPc, effAddr, pushData;
  logic        pushReq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  pcrel_addr_unit i_pcrel_addr_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .pcIn(pcIn), .condTrue(condTrue), .resultValid(resultValid),
    .nextPc(nextPc), .effAddr(effAddr), .pushReq(pushReq), .pushData(pushData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1: sign extension of the low 24 bits
  function automatic logic [31:0] sext24(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  localparam logic [7:0]  OPS  [7] = '{8'h10, 8'h11, 8'h20, 8'h30, 8'h31, 8'h00, 8'hFF};
  localparam logic [23:0] DISP [6] = '{24'h000000, 24'h000001, 24'h7FFFFF,
                                      24'h800000, 24'hFFFFFF, 24'h123456};
  localparam logic [31:0] PCS  [5] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                                      32'h8000_0000, 32'h1234_5678};

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] expNext, expEa, expData, seq, tgt;
    logic        expPush;
    string       tag;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 resultValid", {31'd0, resultValid}, 32'd0);
    check("R10 nextPc", nextPc, 32'd0);
    check("R10 effAddr", effAddr, 32'd0);
    check("R10 pushReq", {31'd0, pushReq}, 32'd0);
    check("R10 pushData", pushData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (OPS[o]) foreach (DISP[d]) foreach (PCS[p]) for (int c = 0; c < 2; c++) begin
      seq = PCS[p] + 32'd1;
      tgt = seq + sext24(DISP[d]);   // R7: 32-bit wrap
      expNext = seq; expEa = '0; expData = '0; expPush = 1'b0;
      case (OPS[o])
        8'h10: begin tag = "R2"; expNext = tgt; end
        8'h11: begin tag = "R3"; if (c == 1) expNext = tgt; end
        8'h20: begin tag = "R4"; expNext = tgt; expPush = 1'b1; expData = seq; end
        8'h30: begin tag = "R5"; expEa = tgt; end
        8'h31: begin tag = "R6"; expEa = tgt; expPush = 1'b1; expData = tgt; end
        default: tag = "R8";
      endcase
      inValid = 1'b1; instrWord = {OPS[o], DISP[d]}; pcIn = PCS[p]; condTrue = c[0];
      @(negedge clk);
      check("R9 resultValid", {31'd0, resultValid}, 32'd1);
      check({tag, " R1 R7 nextPc"}, nextPc, expNext);
      check({tag, " R1 R7 effAddr"}, effAddr, expEa);
      check({tag, " pushReq"}, {31'd0, pushReq}, {31'd0, expPush});
      check({tag, " pushData"}, pushData, expData);
      // R11: idle cycle with changed inputs leaves held values
      inValid = 1'b0; instrWord = ~instrWord; pcIn = pcIn ^ 32'h5A5A_A5A5; condTrue = ~condTrue;
      @(negedge clk);
      check("R11 R9 resultValid idle", {31'd0, resultValid}, 32'd0);
      check("R11 pushReq idle", {31'd0, pushReq}, 32'd0);
      check("R11 nextPc held", nextPc, expNext);
      check("R11 effAddr held", effAddr, expEa);
      check("R11 pushData held", pushData, expData);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule